// File: doc/BRIEF.md
# Dual Chip-Enable Asynchronous SRAM Emulator

A synthesizable stand-in for a byte-wide asynchronous static RAM. It can sit at the far end of a testbench, or inside an FPGA in place of a real part. It watches an active-low chip enable, an active-high chip enable, an active-low write strobe and an active-low output enable. It decodes them the way an asynchronous SRAM does, and keeps its bytes in an internal array addressed by a 17-bit address.

All pins are sampled by a fast oversampling clock through a two-flop stage. A write window is open while the device is selected and the write strobe is low. Whichever of the three strobes drops out first closes the window. The byte and address last seen inside the window are committed on the cycle after the window closes. The bidirectional data bus is split into an input byte, an output byte and a drive enable, so that the pad, or the bench's tristate, can be wired outside the block.

Storage depth is set by a parameter. A full-size emulation sets `MEM_AW` to 17. A smaller value keeps the array small, and the address bits above it are then ignored. A count of committed writes is brought out for checking.

Top module: `sram_emu`

## Requirements
- R1: The device is selected only when `ce_a_n`=0 and `ce_b`=1. When it is not selected, `dq_oe` is 0 whatever `we_n` and `oe_n` are, and no byte is stored.
- R2: When selected with `we_n`=1 and `oe_n`=0, `dq_oe`=1 and `dq_o` shows the byte stored at `addr`. This result is present three rising clock edges after the pins settle.
- R3: When selected with `we_n`=1 and `oe_n`=1, `dq_oe`=0.
- R4: When selected with `we_n`=0, the write window is open and `dq_oe`=0, whatever `oe_n` is. The byte on `dq_i` is stored whether `oe_n` is 0 or 1.
- R5: The window closes when `we_n` rises, when `ce_a_n` rises or when `ce_b` falls, whichever happens first. The stored byte and address are those sampled in the last cycle of the window. Earlier values of data or address inside the window leave no trace.
- R6: `wr_count` resets to 0 and rises by exactly one for each closed window. It changes three rising edges after the closing strobe change.
- R7: If the window is closed by `we_n` while the device stays selected with `oe_n`=0, `dq_oe` returns to 1 on the commit cycle and `dq_o` already shows the newly written byte.
- R8: While `rst_n`=0 and right after reset, `dq_oe`=0 and `wr_count`=0.
- R9: Only the low `MEM_AW` address bits select a location. With `MEM_AW`=11, addresses 0x00010 and 0x10010 name the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Byte address |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_i | input | DATA_W | Data bus as seen at the pins |
| dq_o | output | DATA_W | Byte to drive on the data bus |
| dq_oe | output | 1 | Drive enable for the data bus (0 = high impedance) |
| wr_count | output | CNT_W | Number of committed writes |

## Verification
A pin change passes two synchronizer flops and then one output register. Every bus result is therefore due on the third rising edge after the change, and the write count moves on that same edge after the closing strobe change. The driver changes pins on a falling edge and queues each expectation with a due cycle three edges ahead. It then holds the pins for four cycles, so the monitor compares on the falling edge of the due cycle, while the inputs are still stable. The commit-cycle read after a write is queued at the closing edge itself, which checks that the new byte is forwarded, not the stale one.

// File: rtl/sram_emu_pkg.sv
`timescale 1ns/1ps
package sram_emu_pkg;

    // Control strobes as sampled from the pins (bit order fixed: reset value below)
    typedef struct packed {
        logic ce_a_n;
        logic ce_b;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam strobe_t STRB_IDLE = '{ce_a_n: 1'b1, ce_b: 1'b0, we_n: 1'b1, oe_n: 1'b1};

endpackage

// File: rtl/sram_emu_sync.sv
`timescale 1ns/1ps
module sram_emu_sync #(
    parameter int         W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign synced = st_q.s2;

endmodule

// File: rtl/sram_emu_array.sv
`timescale 1ns/1ps
module sram_emu_array #(
    parameter int MEM_AW = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [MEM_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sram_emu_ctrl.sv
`timescale 1ns/1ps
module sram_emu_ctrl
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int MEM_AW = 11,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           strb_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [MEM_AW-1:0] rd_addr,
    output logic              wr_en,
    output logic [MEM_AW-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic [CNT_W-1:0]  wr_count
);

    typedef struct packed {
        logic              win;    // write window seen last cycle
        logic [MEM_AW-1:0] addr;   // address seen last cycle
        logic [DATA_W-1:0] data;   // data seen last cycle
        logic              oe;     // bus drive enable
        logic [DATA_W-1:0] dout;   // bus output byte
        logic [CNT_W-1:0]  count;  // committed writes
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic              sel;
    logic              win_now;
    logic              commit;
    logic [MEM_AW-1:0] cur_addr;

    generate
        if (MEM_AW < ADDR_W) begin : g_alias
            logic unused_addr_hi;
            assign unused_addr_hi = ^addr_s[ADDR_W-1:MEM_AW];
        end
    endgenerate

    always_comb begin
        cur_addr = addr_s[MEM_AW-1:0];
        sel      = !strb_s.ce_a_n && strb_s.ce_b;
        win_now  = sel && !strb_s.we_n;
        commit   = c_q.win && !win_now;

        c_d       = c_q;
        c_d.win   = win_now;
        c_d.addr  = cur_addr;
        c_d.data  = data_s;
        c_d.oe    = sel && strb_s.we_n && !strb_s.oe_n;
        c_d.count = c_q.count + CNT_W'(commit);

        if (!c_d.oe) begin
            c_d.dout = '0;
        end else if (commit && (c_q.addr == cur_addr)) begin
            c_d.dout = c_q.data;           // forward the byte being committed
        end else begin
            c_d.dout = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_addr  = cur_addr;
    assign wr_en    = commit;
    assign wr_addr  = c_q.addr;
    assign wr_data  = c_q.data;
    assign dq_o     = c_q.dout;
    assign dq_oe    = c_q.oe;
    assign wr_count = c_q.count;

endmodule

// File: rtl/sram_emu.sv
`timescale 1ns/1ps
module sram_emu
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int MEM_AW = 11,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_a_n,
    input  logic              ce_b,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic [CNT_W-1:0]  wr_count
);

    localparam int SW = $bits(strobe_t);
    localparam int BW = ADDR_W + DATA_W + SW;
    localparam logic [BW-1:0] BUS_RST = {{ADDR_W{1'b0}}, {DATA_W{1'b0}}, STRB_IDLE};

    logic [BW-1:0]     raw_bus;
    logic [BW-1:0]     syn_bus;
    strobe_t           strb_raw;
    strobe_t           strb_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;

    logic [MEM_AW-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [MEM_AW-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    always_comb begin
        strb_raw.ce_a_n = ce_a_n;
        strb_raw.ce_b   = ce_b;
        strb_raw.we_n   = we_n;
        strb_raw.oe_n   = oe_n;
    end

    assign raw_bus = {addr, dq_i, strb_raw};
    assign {addr_s, data_s, strb_s} = syn_bus;

    sram_emu_sync #(.W(BW), .RST_VAL(BUS_RST)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw_bus),
        .synced (syn_bus)
    );

    sram_emu_ctrl #(
        .ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb_s   (strb_s),
        .addr_s   (addr_s),
        .data_s   (data_s),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .dq_o     (dq_o),
        .dq_oe    (dq_oe),
        .wr_count (wr_count)
    );

    sram_emu_array #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) array_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/sram_emu_chk.sv
`timescale 1ns/1ps
module sram_emu_chk
    import sram_emu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input strobe_t          strb_s,
    input logic             dq_oe,
    input logic [CNT_W-1:0] wr_count
);

    logic sel;
    logic win;
    assign sel = !strb_s.ce_a_n && strb_s.ce_b;
    assign win = sel && !strb_s.we_n;

    p_desel_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel) |-> !dq_oe);

    p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel && strb_s.we_n && !strb_s.oe_n) |-> dq_oe);

    p_out_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel && strb_s.we_n && strb_s.oe_n) |-> !dq_oe);

    p_write_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(win) |-> !dq_oe);

    p_commit_after_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_count != $past(wr_count)) |-> ($past(win, 2) && !$past(win)));

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_count != $past(wr_count)) |-> (wr_count == $past(wr_count) + CNT_W'(1)));

endmodule

bind sram_emu sram_emu_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb_s   (strb_s),
    .dq_oe    (dq_oe),
    .wr_count (wr_count)
);

// File: tb/sram_emu_tb_top.sv
`timescale 1ns/1ps
module sram_emu_tb_top;

    localparam int ADDR_W = 17;
    localparam int MEM_AW = 11;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 16;
    localparam int LAT    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              ce_a_n = 1'b1;
    logic              ce_b = 1'b0;
    logic              we_n = 1'b1;
    logic              oe_n = 1'b1;
    logic [DATA_W-1:0] dq_i = '0;
    logic [DATA_W-1:0] dq_o;
    logic              dq_oe;
    logic [CNT_W-1:0]  wr_count;

    always #2.5 clk = ~clk;

    sram_emu #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_a_n(ce_a_n), .ce_b(ce_b),
        .we_n(we_n), .oe_n(oe_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
        .wr_count(wr_count)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        bit          chk_oe;
        logic        exp_oe;
        bit          chk_dat;
        logic [7:0]  exp_dat;
        bit          chk_cnt;
        int          exp_cnt;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          checks = 0;
    int          errors = 0;
    logic [7:0]  model [int];
    int          n_wr = 0;

    function automatic int key(input logic [ADDR_W-1:0] a);
        return int'(a[MEM_AW-1:0]);
    endfunction

    task automatic push(input bit co, input logic eo, input bit cd, input logic [7:0] ed,
                        input bit cc, input int ec, input string tag);
        item_t it;
        it.due = cyc + LAT; it.chk_oe = co; it.exp_oe = eo; it.chk_dat = cd;
        it.exp_dat = ed; it.chk_cnt = cc; it.exp_cnt = ec; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: compares queued expectations on the falling edge of their due cycle
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                it = sb.pop_front();
                if (it.chk_oe) begin
                    checks++;
                    if (dq_oe !== it.exp_oe) begin
                        errors++;
                        $display("FAIL %s dq_oe actual %0b expected %0b", it.tag, dq_oe, it.exp_oe);
                    end
                end
                if (it.chk_dat) begin
                    checks++;
                    if (dq_o !== it.exp_dat) begin
                        errors++;
                        $display("FAIL %s dq_o actual %02h expected %02h", it.tag, dq_o, it.exp_dat);
                    end
                end
                if (it.chk_cnt) begin
                    checks++;
                    if (int'(wr_count) != it.exp_cnt) begin
                        errors++;
                        $display("FAIL %s wr_count actual %0d expected %0d", it.tag, wr_count, it.exp_cnt);
                    end
                end
            end
        end
    end

    task automatic pins(input logic a_n, input logic b, input logic w_n, input logic o_n,
                        input logic [ADDR_W-1:0] a, input logic [7:0] d);
        ce_a_n = a_n; ce_b = b; we_n = w_n; oe_n = o_n; addr = a; dq_i = d;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_idle();
        @(negedge clk);
        pins(1'b1, 1'b0, 1'b1, 1'b1, '0, '0);
        push(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 0, "R1 idle");
        step(4);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
        @(negedge clk);
        pins(1'b0, 1'b1, 1'b1, 1'b0, a, 8'h5A);
        push(1'b1, 1'b1, 1'b1, model[key(a)], 1'b0, 0, tag);
        step(4);
    endtask

    // term: 0 = we_n rises, 1 = ce_a_n rises, 2 = ce_b falls
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic o_n,
                      input int term, input string tag);
        @(negedge clk);
        pins(1'b0, 1'b1, 1'b0, o_n, a, d);
        push(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 0, "R4 window hi-z");
        step(4);
        case (term)
            1:       ce_a_n = 1'b1;
            2:       ce_b   = 1'b0;
            default: we_n   = 1'b1;
        endcase
        model[key(a)] = d;
        n_wr++;
        push(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, n_wr, "R6 count");
        if (term == 0 && o_n == 1'b0)
            push(1'b1, 1'b1, 1'b1, d, 1'b0, 0, tag);
        step(4);
        go_idle();
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset state
        step(3);
        checks++;
        if (dq_oe !== 1'b0 || wr_count !== '0) begin
            errors++;
            $display("FAIL R8 in reset actual oe=%0b cnt=%0d expected oe=0 cnt=0", dq_oe, wr_count);
        end
        rst_n = 1'b1;
        step(3);
        checks++;
        if (dq_oe !== 1'b0 || wr_count !== '0) begin
            errors++;
            $display("FAIL R8 after reset actual oe=%0b cnt=%0d expected oe=0 cnt=0", dq_oe, wr_count);
        end

        // R4 and R2: plain write closed by we_n, then read back
        wr(17'h00010, 8'hA5, 1'b1, 0, "R7 unused");
        rd(17'h00010, "R2 read back");

        // R7: write with oe_n low, closed by we_n, byte forwarded on the commit cycle
        wr(17'h00033, 8'h3C, 1'b0, 0, "R7 forward on commit");
        rd(17'h00033, "R4 write with oe_n low stored");

        // R5: window closed by ce_a_n, data changed inside the window
        @(negedge clk);
        pins(1'b0, 1'b1, 1'b0, 1'b1, 17'h00044, 8'h11);
        step(3);
        dq_i = 8'h22;
        step(2);
        ce_a_n = 1'b1;
        model[key(17'h00044)] = 8'h22;
        n_wr++;
        push(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, n_wr, "R6 count ce_a_n close");
        step(4);
        go_idle();
        rd(17'h00044, "R5 last data, ce_a_n close");

        // R5: window closed by ce_b
        wr(17'h00055, 8'h96, 1'b1, 2, "R7 unused");
        rd(17'h00055, "R5 ce_b close");

        // R5: address moved inside the window; only the last one is written
        model[key(17'h00066)] = 8'h00;
        wr(17'h00066, 8'h00, 1'b1, 0, "R7 unused");
        @(negedge clk);
        pins(1'b0, 1'b1, 1'b0, 1'b1, 17'h00066, 8'hE7);
        step(3);
        addr = 17'h00077;
        step(3);
        we_n = 1'b1;
        model[key(17'h00077)] = 8'hE7;
        n_wr++;
        push(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, n_wr, "R6 count addr move");
        step(4);
        go_idle();
        rd(17'h00077, "R5 last address written");
        rd(17'h00066, "R5 earlier address untouched");

        // R1: deselected by either enable, with read and write strobes
        @(negedge clk);
        pins(1'b1, 1'b1, 1'b1, 1'b0, 17'h00010, 8'h00);
        push(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 0, "R1 ce_a_n high read");
        step(4);
        @(negedge clk);
        pins(1'b0, 1'b0, 1'b1, 1'b0, 17'h00010, 8'h00);
        push(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 0, "R1 ce_b low read");
        step(4);
        @(negedge clk);
        pins(1'b0, 1'b0, 1'b0, 1'b0, 17'h00010, 8'hFF);
        step(4);
        we_n = 1'b1;
        push(1'b1, 1'b0, 1'b0, 8'h00, 1'b1, n_wr, "R1 no write while deselected");
        step(4);
        go_idle();
        rd(17'h00010, "R1 byte kept while deselected");

        // R3: selected, outputs disabled
        @(negedge clk);
        pins(1'b0, 1'b1, 1'b1, 1'b1, 17'h00010, 8'h00);
        push(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 0, "R3 output disabled");
        step(4);

        // R9: upper address bits alias
        rd(17'h10010, "R9 alias of 0x00010");
        wr(17'h1F7FF, 8'hC3, 1'b1, 0, "R7 unused");
        rd(17'h007FF, "R9 alias of 0x1F7FF");

        go_idle();
        step(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule